// File: doc/BRIEF.md
# Store Queue with Load-First Memory Arbitration

This block sits between a processor's load and store request channels and a single shared memory port. Stores aimed at anything other than the local scratchpad are parked in a small first-in first-out queue and written out oldest first. When the port is free, pending loads get it ahead of queued stores, so load latency is not stretched by write traffic.

Program order is kept where reordering would be visible. A full queue drains before any load issues. A load into the peripheral window waits while any peripheral store is still queued. A read-modify-write load waits until the queue is empty, and a queued read-modify-write store holds back every load until it has been written. A load whose word address matches a queued store also waits, because no forwarding is done. Stores into the scratchpad window go straight out on the scratchpad port in the cycle they are presented. An empty flag lets a synchronising instruction wait until every buffered store has been accepted by memory.

Top module: `store_queue_arb`

## Requirements
- R1: When a load is presented and none of the blocking conditions of R2, R3, R4 or R6 holds, the memory port carries that load (mem_valid high, mem_write low, mem_addr equal to ld_addr), even with stores queued, and ld_ready equals mem_ready.
- R2: While DEPTH stores are queued, no load is issued: the port carries the oldest store, and a store outside the scratchpad window sees st_ready low.
- R3: An address is in the peripheral window when (addr & PER_MASK) == PER_BASE. A peripheral load is not issued while any queued store has a peripheral address.
- R4: A load with ld_rmw high is not issued until the queue is empty, and no load is issued while a store that was presented with st_rmw high is still queued.
- R5: An address is in the scratchpad window when (addr & SPM_MASK) == SPM_BASE. A store there is accepted in the same cycle (st_ready high), appears on spm_we/spm_addr/spm_data/spm_be in that cycle, and is never queued.
- R6: A load whose word address (addr bits above bit 1) matches any queued store is not issued until that store has drained.
- R7: Queued stores leave on the memory port strictly in arrival order with the address, data and byte enables they were presented with; mem_valid stays high while any store is queued.
- R8: buf_empty is high exactly when no store is queued, and no write is presented on the memory port while it is high.
- R9: During reset the queue is empty: buf_empty high and mem_valid low with no request presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request present |
| ld_ready | output | 1 | Load accepted by the memory port this cycle |
| ld_addr | input | AW | Load byte address |
| ld_rmw | input | 1 | Load is the read half of a read-modify-write |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | AW | Store byte address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_rmw | input | 1 | Store is the write half of a read-modify-write |
| spm_we | output | 1 | Scratchpad write strobe |
| spm_addr | output | AW | Scratchpad write address |
| spm_data | output | DW | Scratchpad write data |
| spm_be | output | DW/8 | Scratchpad byte enables |
| mem_valid | output | 1 | Memory port request present |
| mem_ready | input | 1 | Memory port accepts the request |
| mem_write | output | 1 | Request is a store (high) or a load (low) |
| mem_addr | output | AW | Memory port address |
| mem_wdata | output | DW | Memory port write data |
| mem_be | output | DW/8 | Memory port byte enables |
| buf_empty | output | 1 | No store is queued |

## Verification
The two functions that collide are a fresh load and the drain of the oldest queued store, both wanting the one memory port in the same cycle. The bench provokes this by queuing stores with mem_ready held low or random, then presenting loads whose addresses fall in the ordinary, peripheral or matching-word space, with and without the read-modify-write flag. Each cycle a reference model of the queue decides whether the load should win or be held, and the observed port command, ld_ready and the order of drained stores are judged against it, with a failure naming the rule that chose the winner.

// File: rtl/store_queue_arb.sv
module store_queue_arb #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 4,
  parameter logic [AW-1:0] PER_BASE = 32'h4000_0000,
  parameter logic [AW-1:0] PER_MASK = 32'hF000_0000,
  parameter logic [AW-1:0] SPM_BASE = 32'h7000_0000,
  parameter logic [AW-1:0] SPM_MASK = 32'hF000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_rmw,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [DW/8-1:0] st_be,
  input  logic          st_rmw,
  output logic          spm_we,
  output logic [AW-1:0] spm_addr,
  output logic [DW-1:0] spm_data,
  output logic [DW/8-1:0] spm_be,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW/8-1:0] mem_be,
  output logic          buf_empty
);
  localparam int BW = DW / 8;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]    e_addr [DEPTH];
  logic [DW-1:0]    e_data [DEPTH];
  logic [BW-1:0]    e_be   [DEPTH];
  logic [DEPTH-1:0] vld, e_per, e_rmw, hit;
  logic [PW-1:0]    wr_ptr, rd_ptr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    assign hit[i] = vld[i] && (e_addr[i][AW-1:2] == ld_addr[AW-1:2]);
  end

  wire full   = &vld;
  wire any_p  = |(vld & e_per);
  wire any_r  = |(vld & e_rmw);
  wire ld_per = (ld_addr & PER_MASK) == PER_BASE;
  wire st_spm = (st_addr & SPM_MASK) == SPM_BASE;

  wire ld_block = full || (ld_rmw && !buf_empty) || any_r || (ld_per && any_p) || (|hit);
  wire ld_go    = ld_valid && !ld_block;
  wire drain    = !ld_go && !buf_empty && mem_ready;
  wire push     = st_valid && st_ready && !st_spm;

  assign buf_empty = ~|vld;
  assign st_ready  = st_spm || !full;
  assign spm_we    = st_valid && st_spm;
  assign spm_addr  = st_addr;
  assign spm_data  = st_data;
  assign spm_be    = st_be;

  assign mem_valid = ld_go || !buf_empty;
  assign mem_write = !ld_go;
  assign mem_addr  = ld_go ? ld_addr : e_addr[rd_ptr];
  assign mem_wdata = e_data[rd_ptr];
  assign mem_be    = ld_go ? {BW{1'b1}} : e_be[rd_ptr];
  assign ld_ready  = ld_go && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (drain) begin
        vld[rd_ptr] <= 1'b0;
        rd_ptr      <= rd_ptr + 1'b1;
      end
      if (push) begin
        vld[wr_ptr] <= 1'b1;
        wr_ptr      <= wr_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      e_addr[wr_ptr] <= st_addr;
      e_data[wr_ptr] <= st_data;
      e_be[wr_ptr]   <= st_be;
      e_per[wr_ptr]  <= (st_addr & PER_MASK) == PER_BASE;
      e_rmw[wr_ptr]  <= st_rmw;
    end
  end
endmodule

// File: rtl/store_queue_arb_chk.sv
module store_queue_arb_chk #(
  parameter int AW = 32,
  parameter int DEPTH = 4,
  parameter logic [AW-1:0] PER_BASE = 32'h4000_0000,
  parameter logic [AW-1:0] PER_MASK = 32'hF000_0000,
  parameter logic [AW-1:0] SPM_BASE = 32'h7000_0000,
  parameter logic [AW-1:0] SPM_MASK = 32'hF000_0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_ready,
  input logic [AW-1:0] ld_addr,
  input logic          ld_rmw,
  input logic          st_valid,
  input logic          st_ready,
  input logic [AW-1:0] st_addr,
  input logic          spm_we,
  input logic          mem_valid,
  input logic          mem_write,
  input logic          buf_empty,
  input logic [DEPTH-1:0] vld,
  input logic [DEPTH-1:0] e_per,
  input logic [AW-1:0] e_addr [DEPTH]
);
  logic word_hit;
  always_comb begin
    word_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld[i] && e_addr[i][AW-1:2] == ld_addr[AW-1:2]) word_hit = 1'b1;
  end

  wire in_spm = (st_addr & SPM_MASK) == SPM_BASE;
  wire in_per = (ld_addr & PER_MASK) == PER_BASE;

  p_full_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&vld) && mem_valid |-> mem_write);
  p_full_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&vld) && st_valid && !in_spm |-> !st_ready);
  p_periph_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready && in_per |-> (vld & e_per) == '0);
  p_rmw_drained_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready && ld_rmw |-> vld == '0);
  p_spm_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && in_spm |-> spm_we && st_ready);
  p_no_hazard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> !word_hit);
  p_empty_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> !(mem_valid && mem_write));
endmodule

bind store_queue_arb store_queue_arb_chk #(
  .AW(AW), .DEPTH(DEPTH), .PER_BASE(PER_BASE), .PER_MASK(PER_MASK),
  .SPM_BASE(SPM_BASE), .SPM_MASK(SPM_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_rmw(ld_rmw),
  .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .spm_we(spm_we),
  .mem_valid(mem_valid), .mem_write(mem_write), .buf_empty(buf_empty),
  .vld(vld), .e_per(e_per), .e_addr(e_addr)
);

// File: tb/store_queue_arb_bench.sv
`timescale 1ns/1ps
module store_queue_arb_bench;
  localparam int DEPTH = 4;
  localparam logic [31:0] PB = 32'h4000_0000, PM = 32'hF000_0000;
  localparam logic [31:0] SB = 32'h7000_0000, SM = 32'hF000_0000;

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, ld_rmw = 0, st_valid = 0, st_rmw = 0, mem_ready = 0;
  logic [31:0] ld_addr = 0, st_addr = 0, st_data = 0;
  logic [3:0] st_be = 0;
  logic ld_ready, st_ready, spm_we, mem_valid, mem_write, buf_empty;
  logic [31:0] spm_addr, spm_data, mem_addr, mem_wdata;
  logic [3:0] spm_be, mem_be;

  always #2.5 clk = ~clk;

  store_queue_arb u_store_queue_arb (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_rmw(ld_rmw), .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be), .st_rmw(st_rmw), .spm_we(spm_we), .spm_addr(spm_addr),
    .spm_data(spm_data), .spm_be(spm_be), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .buf_empty(buf_empty));

  typedef struct { logic [31:0] a; logic [31:0] d; logic [3:0] be; bit per; bit rmw; } ent_t;
  ent_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic bit in_win(logic [31:0] a, logic [31:0] b, logic [31:0] m);
    return (a & m) == b;
  endfunction

  function automatic logic [31:0] rnd_addr();
    int r = $urandom % 4;
    logic [31:0] off = 32'(($urandom % 8) * 4 + ($urandom % 4));
    case (r)
      2: return PB + off;
      3: return SB + off;
      default: return off;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit lv, logic [31:0] la, bit lr, bit sv, logic [31:0] sa,
                      logic [31:0] sd, logic [3:0] sbe, bit sr, bit mr);
    bit full, anyp, anyr, match, elig, sspm, exp_sr, exp_mv;
    string why;
    @(negedge clk);
    ld_valid = lv; ld_addr = la; ld_rmw = lr;
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sbe; st_rmw = sr;
    mem_ready = mr;
    #1;
    full = q.size() == DEPTH;
    anyp = 0; anyr = 0; match = 0;
    foreach (q[i]) begin
      anyp |= q[i].per; anyr |= q[i].rmw;
      match |= (q[i].a[31:2] == la[31:2]);
    end
    why = "R1";
    if (full) why = "R2";
    else if (lr && q.size() > 0) why = "R4";
    else if (anyr) why = "R4";
    else if (in_win(la, PB, PM) && anyp) why = "R3";
    else if (match) why = "R6";
    elig = lv && why == "R1";
    sspm = in_win(sa, SB, SM);
    exp_sr = sspm || !full;
    exp_mv = elig || q.size() > 0;
    chk(st_ready == exp_sr, sspm ? "R5 st_ready" : "R2 st_ready", 64'(st_ready), 64'(exp_sr));
    chk(spm_we == (sv && sspm), "R5 spm_we", 64'(spm_we), 64'(sv && sspm));
    if (sv && sspm)
      chk(spm_addr == sa && spm_data == sd && spm_be == sbe, "R5 spm fields",
          {spm_addr, spm_data}, {sa, sd});
    chk(mem_valid == exp_mv, elig ? "R1 mem_valid" : "R7 mem_valid", 64'(mem_valid), 64'(exp_mv));
    if (exp_mv) begin
      chk(mem_write == !elig, {why, " mem_write"}, 64'(mem_write), 64'(!elig));
      if (elig) chk(mem_addr == la, "R1 mem_addr", 64'(mem_addr), 64'(la));
      else chk(mem_addr == q[0].a && mem_wdata == q[0].d && mem_be == q[0].be, "R7 head store",
               {mem_addr, mem_wdata}, {q[0].a, q[0].d});
    end
    chk(ld_ready == (elig && mr), lv ? {why, " ld_ready"} : "R1 ld_ready", 64'(ld_ready), 64'(elig && mr));
    chk(buf_empty == (q.size() == 0), "R8 buf_empty", 64'(buf_empty), 64'(q.size() == 0));
    if (exp_mv && mr && !elig) void'(q.pop_front());
    if (sv && exp_sr && !sspm) q.push_back('{sa, sd, sbe, in_win(sa, PB, PM), sr});
  endtask

  task automatic st(logic [31:0] a, logic [31:0] d, bit r, bit mr);
    step(0, 0, 0, 1, a, d, 4'hF, r, mr);
  endtask
  task automatic ld(logic [31:0] a, bit r, bit mr);
    step(1, a, r, 0, 0, 0, 0, 0, mr);
  endtask
  task automatic idle_drain();
    while (q.size() > 0) step(0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (2) @(negedge clk);
    #1;
    chk(buf_empty == 1'b1, "R9 reset empty", 64'(buf_empty), 64'd1);
    chk(mem_valid == 1'b0, "R9 reset mem_valid", 64'(mem_valid), 64'd0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < DEPTH; i++) st(32'h100 + 32'(i * 4), 32'hA0 + 32'(i), 0, 0);
    ld(32'h200, 0, 1);                      // R2 full: store drains
    st(32'h300, 32'h5, 0, 0);               // R2 refill
    st(SB + 32'h8, 32'h77, 0, 0);           // R5 bypass while full
    idle_drain();

    st(PB + 32'h10, 32'h11, 0, 0);
    ld(PB + 32'h20, 0, 0);                  // R3 held
    ld(PB + 32'h20, 0, 1);                  // R3 held, store drains
    ld(PB + 32'h20, 0, 1);                  // R1 now granted

    st(32'h40, 32'h22, 0, 0);
    ld(32'h42, 0, 0);                       // R6 same word
    ld(32'h44, 0, 1);                       // R1 other word wins over queued store
    idle_drain();

    st(32'h80, 32'h33, 0, 0);
    ld(32'h90, 1, 1);                       // R4 rmw load waits
    ld(32'h90, 1, 1);                       // R4 granted on empty queue
    st(32'h90, 32'h44, 1, 0);
    ld(32'hA0, 0, 1);                       // R4 held behind rmw store
    ld(32'hA0, 0, 1);                       // R1 after drain

    for (int n = 0; n < 4000; n++)
      step($urandom % 2, rnd_addr(), ($urandom % 8) == 0, $urandom % 2, rnd_addr(),
           $urandom, 4'($urandom % 15 + 1), ($urandom % 8) == 0, ($urandom % 4) != 0);
    idle_drain();
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule